// File: doc/BRIEF.md
# Memory Window Base Register and Address Claim

This block holds the 32-bit configuration base register for a 4 KB memory-mapped register window and decides, one address phase at a time, whether the device should claim a bus access. Host software finds the window size by writing all ones and reading the register back. It then places the window anywhere in 32-bit memory space by writing the upper address bits. The low bits of the register are fixed. They report a 32-bit, memory-space window whose prefetchable flag is the inverse of a prefetch-disable input. That input is loaded from non-volatile configuration elsewhere on the chip.

Once the command register's memory-enable bit is set, the block compares each address phase against the stored base. The phase must carry one of the memory commands. On a match it raises a registered claim one clock later, together with the 12-bit offset into the window, which downstream logic uses to pick a register. Reads in the first 32 bytes of the window have side effects. For that reason, a multi-phase burst that starts there is flagged for disconnection. A hard reset clears the base. A soft reset only drops any pending claim.

Top module: `memwin_bar`

## Requirements
- R1: While `hrst_n` is low and after it is released, the base field is zero, so `cfg_rdata[31:12]` reads 0.
- R2: `cfg_rdata[11:4]` always reads zero, so writing 32'hFFFF_FFFF with all byte enables reads back 32'hFFFF_F000 plus the bit-3 flag, which is a 4 KB size requirement.
- R3: `cfg_rdata[2:0]` always reads 3'b000 (memory space, 32-bit type), whatever value is written.
- R4: `cfg_rdata[3]` always equals the inverse of `prefetch_dis`, and writes do not change it.
- R5: A write with `cfg_wr` high updates only the base bits inside enabled byte lanes. `cfg_be[1]` covers bits 15:12, `cfg_be[2]` covers bits 23:16 and `cfg_be[3]` covers bits 31:24. `cfg_be[0]` changes nothing. Without `cfg_wr`, the base holds.
- R6: `soft_rst` leaves the base unchanged and forces `claim`, `disconnect` and `claim_offset` to zero on the next clock.
- R7: When `addr_valid`, `mem_en` and a memory command are present at a clock edge, and `ad[31:12]` equals the base, `claim` is 1 for the following cycle.
- R8: There is no claim if `mem_en` is 0, if `ad[31:12]` differs from the base, or if `bus_cmd` is not one of the memory commands 4'b0110, 4'b0111, 4'b1100, 4'b1110 or 4'b1111.
- R9: Together with `claim`, `claim_offset` gives `ad[11:0]` of the claimed phase. It reads 0 in any cycle without a claim.
- R10: `disconnect` is 1 exactly when a claim is made with `burst` high and the offset below 12'h020. A claim at offset 12'h020 or above, or one with `burst` low, gives 0.
- R11: `claim` is a single-cycle pulse. It drops in the cycle after any edge without a qualifying address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hrst_n | input | 1 | Asynchronous active-low hard reset; clears the base |
| soft_rst | input | 1 | Synchronous soft reset; clears claim outputs only |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Register readback value |
| mem_en | input | 1 | Memory-space enable from the command register |
| prefetch_dis | input | 1 | Prefetch-disable configuration bit |
| addr_valid | input | 1 | Current cycle is an address phase |
| bus_cmd | input | 4 | Bus command of the address phase |
| ad | input | 32 | Address of the address phase |
| burst | input | 1 | Access will carry more than one data phase |
| claim | output | 1 | Registered device-select claim |
| claim_offset | output | 12 | Window offset of the claimed access |
| disconnect | output | 1 | Claimed burst must be disconnected |

## Verification
The bench goes after the sizing readback and partial byte-enable writes. A design that let a low bit become writable, or ignored lane masking, would read back a wrong size or a wrong base. It sweeps all sixteen commands against a matching address and also tries a cleared enable. A loose command decoder would then claim I/O or configuration cycles. It probes the disconnect edge at offsets 0x000, 0x01F and 0x020, where an off-by-one compare shows up at once. It also pulses soft reset during a matching phase, to show that the pending claim is dropped while the base is kept.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  typedef enum logic [3:0] {
    CMD_MRD   = 4'b0110,
    CMD_MWR   = 4'b0111,
    CMD_MRDM  = 4'b1100,
    CMD_MRDL  = 4'b1110,
    CMD_MWRI  = 4'b1111
  } mem_cmd_e;

  // True for the bus commands that address memory space.
  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    logic r;
    case (cmd)
      CMD_MRD, CMD_MWR, CMD_MRDM, CMD_MRDL, CMD_MWRI: r = 1'b1;
      default:                                        r = 1'b0;
    endcase
    return r;
  endfunction

  // Byte lane that carries a given address bit.
  function automatic int lane_of(input int bit_pos);
    return bit_pos / 8;
  endfunction

endpackage

// File: rtl/memwin_base_reg.sv
module memwin_base_reg #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 12,
  localparam int BE_W    = ADDR_W / 8,
  localparam int BASE_W  = ADDR_W - WIN_LOG2,
  localparam int ZERO_W  = WIN_LOG2 - 4
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              prefetch_dis,
  output logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] rdata
);
  import memwin_pkg::*;

  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] lane_on;   // per-bit write permission from byte enables

  for (genvar i = 0; i < BASE_W; i++) begin : g_lane
    localparam int LANE = lane_of(i + WIN_LOG2);
    assign lane_on[i] = be[LANE];
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      base_q <= '0;
    end else if (wr) begin
      base_q <= (base_q & ~lane_on) | (wdata[ADDR_W-1:WIN_LOG2] & lane_on);
    end
  end

  assign base  = base_q;
  assign rdata = {base_q, {ZERO_W{1'b0}}, ~prefetch_dis, 3'b000};

  // R5: base only moves on a write
  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!hrst_n)
    !wr |=> $stable(base_q));

  // R5: a write with every base lane disabled leaves the base alone
  a_r5_masked_write: assert property (@(posedge clk) disable iff (!hrst_n)
    (wr && lane_on == '0) |=> $stable(base_q));

endmodule

// File: rtl/memwin_addr_match.sv
module memwin_addr_match #(
  parameter int ADDR_W     = 32,
  parameter int WIN_LOG2   = 12,
  parameter int DISC_BYTES = 32,
  localparam int BASE_W    = ADDR_W - WIN_LOG2
) (
  input  logic                addr_valid,
  input  logic                mem_en,
  input  logic [3:0]          cmd,
  input  logic [ADDR_W-1:0]   ad,
  input  logic                burst,
  input  logic [BASE_W-1:0]   base,
  output logic                hit,
  output logic                hit_low_burst,
  output logic [WIN_LOG2-1:0] offset
);
  import memwin_pkg::*;

  localparam logic [WIN_LOG2-1:0] DISC_LIM = WIN_LOG2'(DISC_BYTES);

  logic cmd_ok;
  logic base_eq;
  logic in_low;

  assign cmd_ok        = is_mem_cmd(cmd);
  assign base_eq       = (ad[ADDR_W-1:WIN_LOG2] == base);
  assign offset        = ad[WIN_LOG2-1:0];
  assign in_low        = (offset < DISC_LIM);
  assign hit           = addr_valid && mem_en && cmd_ok && base_eq;
  assign hit_low_burst = hit && burst && in_low;

endmodule

// File: rtl/memwin_claim_pipe.sv
module memwin_claim_pipe #(
  parameter int WIN_LOG2   = 12,
  parameter int DISC_BYTES = 32
) (
  input  logic                clk,
  input  logic                hrst_n,
  input  logic                soft_rst,
  input  logic                hit,
  input  logic                hit_low_burst,
  input  logic [WIN_LOG2-1:0] offset,
  output logic                claim,
  output logic                disconnect,
  output logic [WIN_LOG2-1:0] claim_offset
);
  localparam logic [WIN_LOG2-1:0] DISC_LIM = WIN_LOG2'(DISC_BYTES);

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      claim        <= 1'b0;
      disconnect   <= 1'b0;
      claim_offset <= '0;
    end else if (soft_rst) begin
      claim        <= 1'b0;
      disconnect   <= 1'b0;
      claim_offset <= '0;
    end else begin
      claim        <= hit;
      disconnect   <= hit_low_burst;
      claim_offset <= hit ? offset : '0;
    end
  end

  // R7: a qualifying phase is claimed on the next cycle
  a_r7_claim_follows_hit: assert property (@(posedge clk) disable iff (!hrst_n)
    (hit && !soft_rst) |=> claim);

  // R11: the claim is one cycle wide
  a_r11_claim_pulse: assert property (@(posedge clk) disable iff (!hrst_n)
    !hit |=> !claim);

  // R6: soft reset drops a pending claim
  a_r6_soft_drops_claim: assert property (@(posedge clk) disable iff (!hrst_n)
    soft_rst |=> (!claim && !disconnect));

  // R10: disconnect only accompanies a claim inside the low region
  a_r10_disc_with_claim: assert property (@(posedge clk) disable iff (!hrst_n)
    disconnect |-> (claim && claim_offset < DISC_LIM));

  // R9: offset is zero while unclaimed
  a_r9_offset_idle_zero: assert property (@(posedge clk) disable iff (!hrst_n)
    !claim |-> (claim_offset == '0));

endmodule

// File: rtl/memwin_bar.sv
module memwin_bar #(
  parameter int ADDR_W     = 32,
  parameter int WIN_LOG2   = 12,
  parameter int DISC_BYTES = 32,
  localparam int BE_W      = ADDR_W / 8,
  localparam int BASE_W    = ADDR_W - WIN_LOG2
) (
  input  logic                clk,
  input  logic                hrst_n,
  input  logic                soft_rst,
  input  logic                cfg_wr,
  input  logic [BE_W-1:0]     cfg_be,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  output logic [ADDR_W-1:0]   cfg_rdata,
  input  logic                mem_en,
  input  logic                prefetch_dis,
  input  logic                addr_valid,
  input  logic [3:0]          bus_cmd,
  input  logic [ADDR_W-1:0]   ad,
  input  logic                burst,
  output logic                claim,
  output logic [WIN_LOG2-1:0] claim_offset,
  output logic                disconnect
);

  logic [BASE_W-1:0]   base;
  logic                hit;
  logic                hit_low_burst;
  logic [WIN_LOG2-1:0] offset;

  memwin_base_reg #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_base (
    .clk          (clk),
    .hrst_n       (hrst_n),
    .wr           (cfg_wr),
    .be           (cfg_be),
    .wdata        (cfg_wdata),
    .prefetch_dis (prefetch_dis),
    .base         (base),
    .rdata        (cfg_rdata)
  );

  memwin_addr_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .DISC_BYTES(DISC_BYTES)) u_match (
    .addr_valid    (addr_valid),
    .mem_en        (mem_en),
    .cmd           (bus_cmd),
    .ad            (ad),
    .burst         (burst),
    .base          (base),
    .hit           (hit),
    .hit_low_burst (hit_low_burst),
    .offset        (offset)
  );

  memwin_claim_pipe #(.WIN_LOG2(WIN_LOG2), .DISC_BYTES(DISC_BYTES)) u_pipe (
    .clk           (clk),
    .hrst_n        (hrst_n),
    .soft_rst      (soft_rst),
    .hit           (hit),
    .hit_low_burst (hit_low_burst),
    .offset        (offset),
    .claim         (claim),
    .disconnect    (disconnect),
    .claim_offset  (claim_offset)
  );

  // R8: nothing is claimed unless memory decoding was enabled
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!hrst_n)
    claim |-> $past(mem_en));

  // R8: a claim implies the phase address matched the base in force then
  a_r8_base_match: assert property (@(posedge clk) disable iff (!hrst_n)
    claim |-> ($past(ad[ADDR_W-1:WIN_LOG2]) == $past(base)));

  // R6: soft reset never disturbs the base
  a_r6_soft_keeps_base: assert property (@(posedge clk) disable iff (!hrst_n)
    (soft_rst && !cfg_wr) |=> $stable(base));

endmodule

// File: tb/memwin_bar_bench.sv
module memwin_bar_bench;

  logic        clk = 1'b0;
  logic        hrst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b0;
  logic        prefetch_dis = 1'b1;
  logic        addr_valid = 1'b0;
  logic [3:0]  bus_cmd = '0;
  logic [31:0] ad = '0;
  logic        burst = 1'b0;
  logic        claim;
  logic [11:0] claim_offset;
  logic        disconnect;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  memwin_bar u_memwin_bar (
    .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .prefetch_dis(prefetch_dis),
    .addr_valid(addr_valid), .bus_cmd(bus_cmd), .ad(ad), .burst(burst),
    .claim(claim), .claim_offset(claim_offset), .disconnect(disconnect)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_bar = '0;
  bit          m_claim = 0;
  bit          m_disc = 0;
  logic [11:0] m_off = '0;

  function automatic bit mem_command(input logic [3:0] c);
    return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
  endfunction

  always @(posedge clk) begin
    if (!hrst_n) begin
      m_bar = '0; m_claim = 0; m_disc = 0; m_off = '0;
    end else begin
      bit hit;
      hit = addr_valid && mem_en && mem_command(bus_cmd) && (ad[31:12] == m_bar[31:12]);
      if (soft_rst) begin
        m_claim = 0; m_disc = 0; m_off = '0;
      end else begin
        m_claim = hit;
        m_off   = hit ? ad[11:0] : 12'h0;
        m_disc  = hit && burst && (int'(ad[11:0]) < 32);
      end
      if (cfg_wr) begin
        for (int b = 0; b < 4; b++)
          if (cfg_be[b]) m_bar[8*b +: 8] = cfg_wdata[8*b +: 8];
        m_bar = m_bar & 32'hFFFF_F000;
      end
    end
    #2;
    chk("R7 model claim", {31'b0, claim}, {31'b0, m_claim});
    chk("R9 model offset", {20'b0, claim_offset}, {20'b0, m_off});
    chk("R10 model disconnect", {31'b0, disconnect}, {31'b0, m_disc});
    chk("R2 model readback", cfg_rdata, m_bar | (prefetch_dis ? 32'h0 : 32'h8));
  end

  // ---------------- stimulus helpers ----------------
  task automatic quiet();
    @(negedge clk);
    cfg_wr = 0; soft_rst = 0; addr_valid = 0; burst = 0; bus_cmd = 4'h0; ad = '0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic cfg_write(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = d; cfg_be = be; addr_valid = 0;
    settle();
    quiet();
  endtask

  task automatic phase(input logic [3:0] c, input logic [31:0] a, input bit bst);
    @(negedge clk);
    addr_valid = 1; bus_cmd = c; ad = a; burst = bst; cfg_wr = 0;
    settle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  // ---------------- directed and random test ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset readback", cfg_rdata, 32'h0);
    chk("R1 reset claim", {31'b0, claim}, 32'h0);
    @(negedge clk); hrst_n = 1;
    settle();
    chk("R1 base zero after release", cfg_rdata & 32'hFFFF_F000, 32'h0);

    // R4 prefetch flag follows the inverse of prefetch_dis
    @(negedge clk); prefetch_dis = 0; #1;
    chk("R4 prefetch flag set", cfg_rdata, 32'h8);
    @(negedge clk); prefetch_dis = 1; #1;
    chk("R4 prefetch flag clear", cfg_rdata, 32'h0);
    @(negedge clk); prefetch_dis = 0;

    // R2/R3 sizing readback
    cfg_write(32'hFFFF_FFFF, 4'hF);
    chk("R2 sizing readback", cfg_rdata, 32'hFFFF_F008);
    chk("R3 low bits zero", cfg_rdata & 32'h7, 32'h0);

    // R5 byte lanes
    cfg_write(32'h0, 4'hF);
    cfg_write(32'hFFFF_FFFF, 4'b0001);
    chk("R5 lane0 no effect", cfg_rdata, 32'h0000_0008);
    cfg_write(32'hFFFF_FFFF, 4'b0010);
    chk("R5 lane1", cfg_rdata, 32'h0000_F008);
    cfg_write(32'hFFFF_FFFF, 4'b0100);
    chk("R5 lane2", cfg_rdata, 32'h00FF_F008);
    cfg_write(32'hFFFF_FFFF, 4'b1000);
    chk("R5 lane3", cfg_rdata, 32'hFFFF_F008);

    // program base
    cfg_write(32'hA5C3_7FFF, 4'hF);
    chk("R5 base programmed", cfg_rdata, 32'hA5C3_7008);
    @(negedge clk); mem_en = 1;

    // R7/R9 match
    phase(4'h6, 32'hA5C3_7123, 0);
    chk("R7 claim on match", {31'b0, claim}, 32'h1);
    chk("R9 offset on match", {20'b0, claim_offset}, 32'h123);
    chk("R10 no disc single", {31'b0, disconnect}, 32'h0);
    quiet(); settle();
    chk("R11 claim drops", {31'b0, claim}, 32'h0);
    chk("R9 offset idle zero", {20'b0, claim_offset}, 32'h0);

    // R8 mismatch
    phase(4'h7, 32'hA5C3_8123, 0);
    chk("R8 mismatch no claim", {31'b0, claim}, 32'h0);

    // R8 command sweep
    for (int c = 0; c < 16; c++) begin
      bit exp_c;
      exp_c = (c == 6) || (c == 7) || (c == 12) || (c == 14) || (c == 15);
      phase(4'(c), 32'hA5C3_7040, 0);
      chk($sformatf("R8 command %0h", c), {31'b0, claim}, {31'b0, exp_c});
    end

    // R8 enable cleared
    @(negedge clk); mem_en = 0;
    phase(4'h6, 32'hA5C3_7040, 0);
    chk("R8 enable cleared", {31'b0, claim}, 32'h0);
    @(negedge clk); mem_en = 1;

    // R10 disconnect boundary
    phase(4'hC, 32'hA5C3_7000, 1);
    chk("R10 disc offset 000", {31'b0, disconnect}, 32'h1);
    phase(4'hC, 32'hA5C3_701F, 1);
    chk("R10 disc offset 01F", {31'b0, disconnect}, 32'h1);
    phase(4'hC, 32'hA5C3_7020, 1);
    chk("R10 no disc offset 020", {31'b0, disconnect}, 32'h0);
    chk("R10 claim at 020", {31'b0, claim}, 32'h1);
    phase(4'h6, 32'hA5C3_7010, 0);
    chk("R10 no disc single phase", {31'b0, disconnect}, 32'h0);

    // R6 soft reset during a matching phase
    @(negedge clk);
    addr_valid = 1; bus_cmd = 4'h6; ad = 32'hA5C3_7004; burst = 1; soft_rst = 1;
    settle();
    chk("R6 soft reset drops claim", {31'b0, claim}, 32'h0);
    chk("R6 soft reset drops disc", {31'b0, disconnect}, 32'h0);
    chk("R6 base kept", cfg_rdata, 32'hA5C3_7008);
    quiet();

    // random traffic checked by the model every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      addr_valid   = ($urandom % 3) != 0;
      bus_cmd      = 4'($urandom);
      ad[11:0]     = ($urandom % 2) ? 12'($urandom % 64) : 12'($urandom);
      ad[31:12]    = ($urandom % 2) ? m_bar[31:12] : 20'($urandom);
      burst        = 1'($urandom);
      mem_en       = ($urandom % 10) != 0;
      soft_rst     = ($urandom % 25) == 0;
      prefetch_dis = 1'($urandom);
      cfg_wr       = ($urandom % 30) == 0;
      cfg_be       = 4'($urandom);
      cfg_wdata    = $urandom;
    end
    quiet();

    // R1 hard reset clears base
    @(negedge clk); hrst_n = 0; #1;
    chk("R1 hard reset clears base", cfg_rdata & 32'hFFFF_F000, 32'h0);
    @(negedge clk); hrst_n = 1;
    settle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule